// File: doc/BRIEF.md
# Peripheral Power and Clock Gating Controller

This block decides, for a single peripheral, whether the peripheral has power and whether it gets a clock. It looks at the current device mode (Run, Sleep or Deep-Sleep), at one clock-gating enable bit for each mode, and at a power-retain bit that software holds in a small memory-mapped register. From these inputs it drives a power enable, a clock enable, and a one-cycle reset pulse for the peripheral. The pulse is issued when the peripheral gets power back after a period without power, during which its state was lost.

The enable bit of the current mode takes precedence. When that bit is set, the peripheral is powered and clocked. When it is clear, the retain bit picks between two states: powered with no clock, which keeps the peripheral's state, or fully off, which loses it. All outputs are registered on the system clock. The reset uses an internal lost-state flag, so a peripheral that kept its power never receives a reset.

Top module: `pgc_ctrl`

## Requirements
- R1: The `mode` input selects the enable bit that applies, with `gate_en` indexed as bit 0 = Run, bit 1 = Sleep, bit 2 = Deep-Sleep. The encodings are 2'b00 = Run, 2'b01 = Sleep, 2'b10 = Deep-Sleep, and 2'b11 is treated as Run.
- R2: When the selected enable bit is 1, `pwr_en` and `clk_en` are both 1 after the next clock edge, whatever the retain bit holds.
- R3: When the selected enable bit is 0 and the retain bit is 0, `pwr_en` and `clk_en` are both 0 after the next clock edge.
- R4: When the selected enable bit is 0 and the retain bit is 1, `pwr_en` is 1 and `clk_en` is 0 after the next clock edge.
- R5: The retain bit is bit 0 of the register at address `REG_ADDR` (default 12'h010) and can be read back on `reg_rdata`. A write with `reg_wr` high updates it at the clock edge, and the outputs follow at the edge after that.
- R6: `reg_rdata[31:1]` always reads 0, and writes to those bits are ignored.
- R7: An access to any other address, including an address that is not word-aligned, reads 0 and has no effect on the retain bit.
- R8: Writing the retain bit from 0 to 1 while the peripheral is unpowered raises `periph_rst`.
- R9: A mode change or an enable-bit change that restores power to an unpowered peripheral raises `periph_rst`.
- R10: `periph_rst` lasts exactly one cycle. It is asserted in the same cycle in which `pwr_en` rises from 0 and never at any other time.
- R11: Moving from powered-but-unclocked to clocked produces no `periph_rst`.
- R12: `rst_n` is synchronous and active low. While it is low, the retain bit is loaded with 1, the lost flag is cleared, `pwr_en` is 1, and `clk_en` and `periph_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Current device mode |
| gate_en | input | 3 | Per-mode clock-gating enables (Run, Sleep, Deep-Sleep) |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| pwr_en | output | 1 | Peripheral power enable |
| clk_en | output | 1 | Peripheral clock enable |
| periph_rst | output | 1 | One-cycle peripheral reset pulse |

## Verification
The bench targets the boundary between the retention state and the unpowered state. A design that resets the peripheral on every clock restart would pulse when leaving retention, and a design that only watches register writes would miss a restore caused by a mode change. The bench drives mode 2'b11 to catch a decoder that treats that encoding as Deep-Sleep or as no mode. It also writes all ones to the register, and writes to neighbouring and misaligned addresses, to catch reserved bits that stick and address decoding that is too loose.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int NUM_MODES = 3;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_RUN   = 2'b00,
    MD_SLEEP = 2'b01,
    MD_DEEP  = 2'b10,
    MD_ALT   = 2'b11
  } dev_mode_e;

  // index of the enable bit that governs a given mode
  function automatic int unsigned gate_index(input logic [MODE_W-1:0] m);
    case (m)
      MD_SLEEP: gate_index = 1;
      MD_DEEP:  gate_index = 2;
      default:  gate_index = 0;
    endcase
  endfunction

  function automatic logic power_wanted(input logic gate, input logic retain);
    power_wanted = gate | retain;
  endfunction

  function automatic logic clock_wanted(input logic gate);
    clock_wanted = gate;
  endfunction
endpackage

// File: rtl/pgc_mode_sel.sv
module pgc_mode_sel
  import pgc_pkg::*;
(
  input  logic [MODE_W-1:0]    mode,
  input  logic [NUM_MODES-1:0] gate_en,
  output logic                 gate_sel
);
  logic [NUM_MODES-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_MODES; g++) begin : g_hit
      assign hit[g] = (gate_index(mode) == g) && gate_en[g];
    end
  endgenerate

  assign gate_sel = |hit;
endmodule

// File: rtl/pgc_pwr_reg.sv
module pgc_pwr_reg #(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter logic [11:0] REG_ADDR = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              retain,
  output logic              reg_hit
);
  localparam logic [ADDR_W-1:0] ADDR_MATCH = ADDR_W'(REG_ADDR);

  logic retain_q;

  assign reg_hit = (reg_addr == ADDR_MATCH) && (reg_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n)
      retain_q <= 1'b1;
    else if (reg_wr && reg_hit)
      retain_q <= reg_wdata[0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_hit)
      reg_rdata[0] = retain_q;
  end

  assign retain = retain_q;
endmodule

// File: rtl/pgc_gate_logic.sv
module pgc_gate_logic
  import pgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate_sel,
  input  logic retain,
  output logic pwr_en,
  output logic clk_en,
  output logic periph_rst,
  output logic lost_q,
  output logic pwr_next
);
  logic pwr_q, clk_q, rst_q, clk_next;

  assign pwr_next = power_wanted(gate_sel, retain);
  assign clk_next = clock_wanted(gate_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= 1'b1;
      clk_q  <= 1'b0;
      rst_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      pwr_q  <= pwr_next;
      clk_q  <= clk_next;
      rst_q  <= lost_q & pwr_next;
      lost_q <= ~pwr_next;
    end
  end

  assign pwr_en     = pwr_q;
  assign clk_en     = clk_q;
  assign periph_rst = rst_q;
endmodule

// File: rtl/pgc_ctrl.sv
module pgc_ctrl
  import pgc_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter logic [11:0] REG_ADDR = 12'h010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MODE_W-1:0]    mode,
  input  logic [NUM_MODES-1:0] gate_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 pwr_en,
  output logic                 clk_en,
  output logic                 periph_rst
);
  logic gate_sel, retain, reg_hit, lost_q, pwr_next;

  pgc_mode_sel u_sel (
    .mode     (mode),
    .gate_en  (gate_en),
    .gate_sel (gate_sel)
  );

  pgc_pwr_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .retain    (retain),
    .reg_hit   (reg_hit)
  );

  pgc_gate_logic u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_sel   (gate_sel),
    .retain     (retain),
    .pwr_en     (pwr_en),
    .clk_en     (clk_en),
    .periph_rst (periph_rst),
    .lost_q     (lost_q),
    .pwr_next   (pwr_next)
  );
endmodule

// File: rtl/pgc_ctrl_chk.sv
module pgc_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_sel,
  input logic              retain,
  input logic              lost_q,
  input logic              pwr_en,
  input logic              clk_en,
  input logic              periph_rst,
  input logic [DATA_W-1:0] reg_rdata
);
  // R10
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> (pwr_en && !$past(pwr_en)));

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |=> !periph_rst);

  // R2
  gate_forces_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_sel |=> (pwr_en && clk_en));

  // R4
  retain_unclocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_sel && retain) |=> (pwr_en && !clk_en));

  // R3
  clock_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> pwr_en);

  // R11
  lost_tracks_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !lost_q) |=> !periph_rst);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:1] == '0);
endmodule

bind pgc_ctrl pgc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_sel   (gate_sel),
  .retain     (retain),
  .lost_q     (lost_q),
  .pwr_en     (pwr_en),
  .clk_en     (clk_en),
  .periph_rst (periph_rst),
  .reg_rdata  (reg_rdata)
);

// File: tb/test_pgc_ctrl.sv
module test_pgc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  gate_en = 3'b000;
  logic [11:0] reg_addr = 12'h010;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwr_en, clk_en, periph_rst;

  localparam logic [11:0] RA = 12'h010;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgc_ctrl i_pgc_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .gate_en(gate_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_en(pwr_en), .clk_en(clk_en),
    .periph_rst(periph_rst)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // outputs packed as {pwr_en, clk_en, periph_rst}
  function automatic logic [31:0] outs();
    return {29'b0, pwr_en, clk_en, periph_rst};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0; reg_addr = RA;
  endtask

  task automatic t_reset();
    gate_en = 3'b000; mode = 2'b00; rst_n = 1'b0;
    step(3);
    chk("R12 outputs in reset", outs(), 32'b100);
    chk("R12 retain bit reset", reg_rdata, 32'h1);
    rst_n = 1'b1;
    step(1);
    chk("R4 after reset retain", outs(), 32'b100);
  endtask

  task automatic t_mode_select();
    // retain=1, so the selected bit decides the clock
    mode = 2'b01; gate_en = 3'b010; step(1);
    chk("R1 sleep uses bit1", outs(), 32'b110);
    mode = 2'b10; gate_en = 3'b011; step(1);
    chk("R1 deep ignores bit0/1", outs(), 32'b100);
    gate_en = 3'b100; step(1);
    chk("R1 deep uses bit2", outs(), 32'b110);
    mode = 2'b11; gate_en = 3'b001; step(1);
    chk("R1 mode 11 as run", outs(), 32'b110);
    gate_en = 3'b110; step(1);
    chk("R1 mode 11 ignores bit1/2", outs(), 32'b100);
  endtask

  task automatic t_no_pulse_retain();
    mode = 2'b00; gate_en = 3'b000; step(1);
    chk("R4 retained", outs(), 32'b100);
    gate_en = 3'b001; step(1);
    chk("R11 clock restart no reset", outs(), 32'b110);
    step(1);
    chk("R11 still no reset", outs(), 32'b110);
  endtask

  task automatic t_gate_overrides();
    mode = 2'b00; gate_en = 3'b001;
    wr(RA, 32'h0); step(1);
    chk("R2 gate overrides retain=0", outs(), 32'b110);
  endtask

  task automatic t_pulse_write();
    // retain already 0
    gate_en = 3'b000; step(1);
    chk("R3 unpowered", outs(), 32'b000);
    step(2);
    chk("R3 stays unpowered", outs(), 32'b000);
    wr(RA, 32'h1);
    chk("R5 read back after write", reg_rdata, 32'h1);
    step(1);
    chk("R8 write restores with reset", outs(), 32'b101);
    step(1);
    chk("R10 pulse one cycle", outs(), 32'b100);
  endtask

  task automatic t_pulse_mode();
    mode = 2'b01; gate_en = 3'b001;
    wr(RA, 32'h0); step(1);
    chk("R3 sleep unpowered", outs(), 32'b000);
    mode = 2'b00; step(1);
    chk("R9 mode change restores with reset", outs(), 32'b111);
    step(1);
    chk("R10 pulse ends", outs(), 32'b110);
    gate_en = 3'b000; step(1);
    chk("R3 off again", outs(), 32'b000);
    gate_en = 3'b001; step(1);
    chk("R9 gate change restores with reset", outs(), 32'b111);
    step(1);
    chk("R10 pulse ends again", outs(), 32'b110);
  endtask

  task automatic t_reg_reserved();
    wr(RA, 32'hFFFF_FFFF);
    chk("R6 reserved read zero", reg_rdata, 32'h1);
    wr(RA, 32'hFFFF_FFFE);
    chk("R6 upper bits ignored", reg_rdata, 32'h0);
  endtask

  task automatic t_reg_miss();
    wr(RA + 12'h4, 32'h1);
    chk("R7 other addr no effect", reg_rdata, 32'h0);
    wr(RA + 12'h1, 32'h1);
    chk("R7 misaligned no effect", reg_rdata, 32'h0);
    reg_addr = RA + 12'h4; #0.1;
    chk("R7 other addr reads zero", reg_rdata, 32'h0);
    reg_addr = RA;
    wr(RA, 32'h1);
    chk("R5 write one", reg_rdata, 32'h1);
  endtask

  initial begin
    t_reset();
    t_mode_select();
    t_no_pulse_retain();
    t_gate_overrides();
    t_pulse_write();
    t_pulse_mode();
    t_reg_reserved();
    t_reg_miss();
    t_reset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule